// File: doc/BRIEF.md
# Bank Pin Interrupt Detector

This block watches one bank of general-purpose pins, split into ports of eight pins each, and turns their activity into a single bank interrupt line. Each pin is given its own trigger kind: high level, low level, rising edge, falling edge or either edge. Each pin has a status bit that records the trigger and an enable bit that lets that status reach the interrupt output. The interrupt output is the OR, over the whole bank, of status AND enable.

Software programs the block through a one-cycle write port and a combinational read port. Every port has an enable register, a 24-bit trigger-kind word and a write-one-to-clear command. A masked alias is also decoded for the status, enable and trigger-kind registers. A masked write changes only the bits that it selects. The pin inputs are taken to be already synchronised to `clk`. When a pin is set to level mode, its status bit follows the pin. When a pin is set to edge mode, its status bit latches the event until software clears it.

Top module: `bank_irq_detector`

## Requirements
- R1: While `rst_n` is low and right after it rises, every status, enable and trigger-kind bit reads 0 and `irq` is 0. The read address is `{fn[1:0], port[1:0]}`. fn 0 returns status, fn 1 returns enable, fn 2 returns the trigger word `{both[7:0], edge[7:0], pol[7:0]}`, and fn 3 returns the port's current pin levels. A full write to fn 2 stores all 24 bits.
- R2: In rising mode (pol=1, edge=1, both=0, which is word 0x000101 shifted by the pin index), a 0-to-1 pin change sets the status bit on the next clock. The bit stays set after the pin falls.
- R3: In falling mode (pol=0, edge=1, both=0, which is 0x000100 shifted), only a 1-to-0 change sets status. A rising change leaves it at 0.
- R4: In either-edge mode (edge=1, both=1, which is 0x010100 shifted), both a rise and a fall set status.
- R5: In level-high mode (edge=0, pol=1, which is 0x000001 shifted), status equals the pin one clock later. A clear written while the pin is high does not leave it at 0.
- R6: In level-low mode (all three bits 0), status equals the inverted pin one clock later. This is the mode after reset.
- R7: A write to fn 3 with the masked bit 0 clears the edge-mode status bits whose data bits are 1. Bits written as 0 keep their status.
- R8: When a detected edge and a clear of the same pin fall in the same cycle, the status bit ends up set.
- R9: `irq` is 1 exactly when some pin in some port has both its status bit and its enable bit set.
- R10: A full write to fn 1 loads `wr_data[7:0]` into the enable register. A masked write to fn 1 (write address `{1, fn, port}`) changes only the enable bits selected by `wr_data[15:8]`, setting each selected bit to the matching value bit in `wr_data[7:0]`.
- R11: A masked write to fn 2 applies the select/value pair to one lane of the trigger word, chosen by `wr_data[17:16]`: 0 for pol, 1 for edge, 2 for both. The value 3 changes nothing.
- R12: A masked write to fn 0 sets or clears the selected edge-mode status bits from the value bits. A full write to fn 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins | input | 32 | Synchronised pin levels, with port p on bits 8p+7..8p |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 5 | Write address `{masked, fn[1:0], port[1:0]}` |
| wr_data | input | 24 | Write data |
| rd_addr | input | 4 | Read address `{fn[1:0], port[1:0]}` |
| rd_data | output | 24 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Bank interrupt |

## Verification
The properties assume that `pins` is already synchronous to `clk` and changes only between edges. They also assume that at most one register write arrives per cycle. The bench drives pins, writes and read addresses only on the falling clock edge, and it never issues a masked status write whose select and value fight each other. The hold and follow properties work out the clear mask and the trigger mode only from the write port and the stored mode bits. They therefore rely on a clear reaching a pin solely through the two clear paths and the masked status alias.

// File: rtl/bank_irq_pkg.sv
package bank_irq_pkg;

    // Register function selected by the address field above the port index.
    typedef enum logic [1:0] {
        FN_STATUS = 2'd0,
        FN_ENABLE = 2'd1,
        FN_KIND   = 2'd2,
        FN_CLEAR  = 2'd3
    } reg_fn_e;

    // Lane of the trigger-kind word touched by a masked kind write.
    typedef enum logic [1:0] {
        LANE_POL  = 2'd0,
        LANE_EDGE = 2'd1,
        LANE_BOTH = 2'd2,
        LANE_NONE = 2'd3
    } kind_lane_e;

endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    input  logic edge_mode,
    input  logic both,
    input  logic set_req,
    input  logic clr_req,
    output logic status
);

    logic prev_q;
    logic rise;
    logic fall;
    logic evt;
    logic active;
    logic status_d;

    always_comb begin
        rise     = pin & ~prev_q;
        fall     = ~pin & prev_q;
        active   = ~(pin ^ pol);
        evt      = both ? (rise | fall) : (pol ? rise : fall);
        // Edge mode: the event wins over a clear in the same cycle.
        status_d = edge_mode ? (evt | set_req | (status & ~clr_req)) : active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            status <= 1'b0;
        end else begin
            prev_q <= pin;
            status <= status_d;
        end
    end

endmodule

// File: rtl/irq_port_unit.sv
module irq_port_unit
    import bank_irq_pkg::*;
#(
    parameter int PINS = 8,
    localparam int DW  = 3 * PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] port_pins,
    input  logic            wr_sel,
    input  reg_fn_e         wr_fn,
    input  logic            wr_masked,
    input  logic [DW-1:0]   wr_data,
    output logic [PINS-1:0] status,
    output logic [PINS-1:0] enable,
    output logic [PINS-1:0] pol,
    output logic [PINS-1:0] edg,
    output logic [PINS-1:0] both,
    output logic            hit
);

    logic [PINS-1:0] msel;
    logic [PINS-1:0] mval;
    kind_lane_e      lane;
    logic [PINS-1:0] set_req;
    logic [PINS-1:0] clr_req;

    always_comb begin
        msel = wr_data[2*PINS-1:PINS];
        mval = wr_data[PINS-1:0];
        lane = kind_lane_e'(wr_data[2*PINS+1:2*PINS]);
    end

    // Status set/clear requests coming from the write port.
    always_comb begin
        set_req = '0;
        clr_req = '0;
        if (wr_sel) begin
            unique case (wr_fn)
                FN_STATUS: begin
                    if (wr_masked) begin
                        set_req = msel & mval;
                        clr_req = msel & ~mval;
                    end
                end
                FN_CLEAR: begin
                    if (!wr_masked) clr_req = mval;
                end
                FN_ENABLE, FN_KIND: begin
                    set_req = '0;
                end
            endcase
        end
    end

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (wr_sel && wr_fn == FN_ENABLE) begin
            enable <= wr_masked ? ((enable & ~msel) | (mval & msel)) : mval;
        end
    end

    // Trigger-kind word, three lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol  <= '0;
            edg  <= '0;
            both <= '0;
        end else if (wr_sel && wr_fn == FN_KIND) begin
            if (!wr_masked) begin
                pol  <= wr_data[PINS-1:0];
                edg  <= wr_data[2*PINS-1:PINS];
                both <= wr_data[3*PINS-1:2*PINS];
            end else begin
                unique case (lane)
                    LANE_POL:  pol  <= (pol  & ~msel) | (mval & msel);
                    LANE_EDGE: edg  <= (edg  & ~msel) | (mval & msel);
                    LANE_BOTH: both <= (both & ~msel) | (mval & msel);
                    LANE_NONE: pol  <= pol;
                endcase
            end
        end
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        irq_pin_detect u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (port_pins[i]),
            .pol       (pol[i]),
            .edge_mode (edg[i]),
            .both      (both[i]),
            .set_req   (set_req[i]),
            .clr_req   (clr_req[i]),
            .status    (status[i])
        );
    end

    assign hit = |(status & enable);

endmodule

// File: rtl/bank_irq_detector.sv
module bank_irq_detector
    import bank_irq_pkg::*;
#(
    parameter int PORTS    = 4,
    parameter int PINS     = 8,
    localparam int PORT_AW = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int NPIN    = PORTS * PINS,
    localparam int DW      = 3 * PINS,
    localparam int RAW     = PORT_AW + 2,
    localparam int WAW     = PORT_AW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins,
    input  logic            wr_en,
    input  logic [WAW-1:0]  wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [RAW-1:0]  rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            irq
);

    logic [NPIN-1:0]    status_all;
    logic [NPIN-1:0]    enable_all;
    logic [NPIN-1:0]    type_pol;
    logic [NPIN-1:0]    type_edge;
    logic [NPIN-1:0]    type_both;
    logic [PORTS-1:0]   port_hit;

    logic [PORT_AW-1:0] wport;
    reg_fn_e            wfn;
    logic               wmasked;
    logic [PORT_AW-1:0] rport;
    reg_fn_e            rfn;

    always_comb begin
        wport   = wr_addr[PORT_AW-1:0];
        wfn     = reg_fn_e'(wr_addr[PORT_AW+1:PORT_AW]);
        wmasked = wr_addr[PORT_AW+2];
        rport   = rd_addr[PORT_AW-1:0];
        rfn     = reg_fn_e'(rd_addr[PORT_AW+1:PORT_AW]);
    end

    for (genvar g = 0; g < PORTS; g++) begin : g_port
        irq_port_unit #(.PINS(PINS)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .port_pins (pins[g*PINS +: PINS]),
            .wr_sel    (wr_en && (wport == PORT_AW'(g))),
            .wr_fn     (wfn),
            .wr_masked (wmasked),
            .wr_data   (wr_data),
            .status    (status_all[g*PINS +: PINS]),
            .enable    (enable_all[g*PINS +: PINS]),
            .pol       (type_pol[g*PINS +: PINS]),
            .edg       (type_edge[g*PINS +: PINS]),
            .both      (type_both[g*PINS +: PINS]),
            .hit       (port_hit[g])
        );
    end

    assign irq = |port_hit;

    always_comb begin
        rd_data = '0;
        unique case (rfn)
            FN_STATUS: rd_data[PINS-1:0] = status_all[rport*PINS +: PINS];
            FN_ENABLE: rd_data[PINS-1:0] = enable_all[rport*PINS +: PINS];
            FN_KIND:   rd_data = {type_both[rport*PINS +: PINS],
                                  type_edge[rport*PINS +: PINS],
                                  type_pol[rport*PINS +: PINS]};
            FN_CLEAR:  rd_data[PINS-1:0] = pins[rport*PINS +: PINS];
        endcase
    end

endmodule

// File: rtl/bank_irq_checker.sv
module bank_irq_checker
    import bank_irq_pkg::*;
#(
    parameter int PORTS    = 4,
    parameter int PINS     = 8,
    localparam int PORT_AW = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int NPIN    = PORTS * PINS,
    localparam int DW      = 3 * PINS,
    localparam int WAW     = PORT_AW + 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NPIN-1:0] pins,
    input logic            wr_en,
    input logic [WAW-1:0]  wr_addr,
    input logic [DW-1:0]   wr_data,
    input logic            irq,
    input logic [NPIN-1:0] status_all,
    input logic [NPIN-1:0] enable_all,
    input logic [NPIN-1:0] type_pol,
    input logic [NPIN-1:0] type_edge
);

    logic [NPIN-1:0] clr_vec;
    logic [NPIN-1:0] lvl_active;

    // Bits that the write port may knock down this cycle.
    always_comb begin
        clr_vec = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (wr_en && wr_addr[PORT_AW-1:0] == PORT_AW'(p)) begin
                if (wr_addr[PORT_AW+1:PORT_AW] == FN_CLEAR && !wr_addr[PORT_AW+2])
                    clr_vec[p*PINS +: PINS] = wr_data[PINS-1:0];
                if (wr_addr[PORT_AW+1:PORT_AW] == FN_STATUS && wr_addr[PORT_AW+2])
                    clr_vec[p*PINS +: PINS] = wr_data[2*PINS-1:PINS];
            end
        end
        lvl_active = ~(pins ^ type_pol);
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (enable_all == '0 && type_pol == '0 && type_edge == '0 && !irq));

    assert_edge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_all & type_edge & ~clr_vec) & ~status_all) == '0));

    assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status_all ^ $past(lvl_active)) & $past(~type_edge)) == '0));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_all == '0) |-> !irq);

endmodule

bind bank_irq_detector bank_irq_checker #(.PORTS(PORTS), .PINS(PINS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins       (pins),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .irq        (irq),
    .status_all (status_all),
    .enable_all (enable_all),
    .type_pol   (type_pol),
    .type_edge  (type_edge)
);

// File: tb/test_bank_irq_detector.sv
`timescale 1ns/1ps
module test_bank_irq_detector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [23:0] rd_data;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        bit          is_irq;
        logic [23:0] exp;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    bank_irq_detector i_bank_irq_detector (
        .clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    localparam bit [1:0] ST = 2'd0, EN = 2'd1, KD = 2'd2, CL = 2'd3;

    function automatic logic [4:0] wa(bit m, bit [1:0] fn, bit [1:0] port);
        return {m, fn, port};
    endfunction

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            item_t it;
            logic [23:0] act;
            wait (sb.size() > 0);
            it  = sb.pop_front();
            act = it.is_irq ? {23'd0, irq} : rd_data;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    task automatic exp_rd(string req, bit [1:0] fn, bit [1:0] port, logic [23:0] exp);
        item_t it;
        rd_addr = {fn, port};
        #1;
        it.req = req; it.is_irq = 1'b0; it.exp = exp;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic exp_irq(string req, bit exp);
        item_t it;
        #1;
        it.req = req; it.is_irq = 1'b1; it.exp = {23'd0, exp};
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic wr(logic [4:0] a, logic [23:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setp(logic [31:0] v);
        @(negedge clk);
        pins = v;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        exp_rd("R1 status in reset", ST, 0, 24'h0);
        exp_rd("R1 enable in reset", EN, 0, 24'h0);
        exp_rd("R1 kind in reset", KD, 0, 24'h0);
        exp_irq("R1 irq in reset", 1'b0);
        @(negedge clk); rst_n = 1'b1;
        exp_rd("R1 kind after reset", KD, 0, 24'h0);
        @(negedge clk);
        exp_rd("R6 level low default", ST, 0, 24'hFF);
        exp_rd("R6 level low port3", ST, 3, 24'hFF);

        // port0: pin0 rise, pin1 fall, pin2 both, pin3 level high
        wr(wa(0, KD, 0), 24'h040709);
        exp_rd("R1 kind readback", KD, 0, 24'h040709);
        wr(wa(0, CL, 0), 24'h000007);
        exp_rd("R7 clear edge bits", ST, 0, 24'hF0);

        setp(32'h01);
        exp_rd("R2 rising sets", ST, 0, 24'hF1);
        setp(32'h00);
        exp_rd("R2 rising holds", ST, 0, 24'hF1);

        setp(32'h02);
        exp_rd("R3 rise ignored", ST, 0, 24'hF1);
        setp(32'h00);
        exp_rd("R3 falling sets", ST, 0, 24'hF3);

        wr(wa(0, CL, 0), 24'h000001);
        exp_rd("R7 zero bits keep", ST, 0, 24'hF2);
        wr(wa(0, CL, 0), 24'h000002);
        exp_rd("R7 clear pin1", ST, 0, 24'hF0);

        setp(32'h04);
        exp_rd("R4 rise sets", ST, 0, 24'hF4);
        wr(wa(0, CL, 0), 24'h000004);
        setp(32'h00);
        exp_rd("R4 fall sets", ST, 0, 24'hF4);
        wr(wa(0, CL, 0), 24'h000004);

        setp(32'h08);
        exp_rd("R5 level high follows", ST, 0, 24'hF8);
        wr(wa(0, CL, 0), 24'h000008);
        exp_rd("R5 clear does not stick", ST, 0, 24'hF8);
        setp(32'h00);
        exp_rd("R5 level drops", ST, 0, 24'hF0);
        setp(32'h10);
        exp_rd("R6 level low drops", ST, 0, 24'hE0);
        setp(32'h00);
        exp_rd("R6 level low returns", ST, 0, 24'hF0);

        // R9 / R10
        wr(wa(0, EN, 0), 24'h000001);
        exp_irq("R9 no enabled status", 1'b0);
        setp(32'h01);
        exp_irq("R9 enabled edge", 1'b1);
        setp(32'h00);
        wr(wa(0, CL, 0), 24'h000001);
        exp_irq("R9 cleared", 1'b0);
        wr(wa(0, EN, 2), 24'h000080);
        exp_irq("R9 other port", 1'b1);
        wr(wa(1, EN, 2), 24'h008000);
        exp_rd("R10 masked clear enable", EN, 2, 24'h00);
        exp_irq("R10 irq after masked clear", 1'b0);
        wr(wa(1, EN, 0), 24'h002020);
        exp_rd("R10 masked set keeps others", EN, 0, 24'h21);
        exp_irq("R9 level pin enabled", 1'b1);
        wr(wa(0, EN, 0), 24'h000000);
        exp_irq("R9 all disabled", 1'b0);

        // R8 edge beats clear
        @(negedge clk);
        pins = 32'h01;
        wr_addr = wa(0, CL, 0); wr_data = 24'h000001; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        exp_rd("R8 edge wins over clear", ST, 0, 24'hF1);
        setp(32'h00);
        wr(wa(0, CL, 0), 24'h000001);
        exp_rd("R8 cleared afterwards", ST, 0, 24'hF0);

        // R11 masked kind lanes on port1 pin3
        wr(wa(1, KD, 1), 24'h010808);
        exp_rd("R11 edge lane", KD, 1, 24'h000800);
        wr(wa(1, KD, 1), 24'h000808);
        exp_rd("R11 pol lane", KD, 1, 24'h000808);
        wr(wa(0, CL, 1), 24'h000008);
        exp_rd("R7 port1 clear", ST, 1, 24'hF7);
        setp(32'h0000_0800);
        exp_rd("R11 rising via lanes", ST, 1, 24'hFF);
        exp_rd("R1 pin readback", CL, 1, 24'h08);
        wr(wa(1, KD, 1), 24'h03FFFF);
        exp_rd("R11 lane 3 ignored", KD, 1, 24'h000808);

        // R12 masked status
        wr(wa(1, ST, 1), 24'h000800);
        exp_rd("R12 masked status clear", ST, 1, 24'hF7);
        wr(wa(1, ST, 1), 24'h000808);
        exp_rd("R12 masked status set", ST, 1, 24'hFF);
        wr(wa(0, ST, 1), 24'h000000);
        exp_rd("R12 full status write ignored", ST, 1, 24'hFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule